// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Issuer

This block holds the command register that software uses to send an inter-processor interrupt from one local interrupt controller, and the engine that sends it. Software writes the command as two 32-bit halves. The high half holds an 8-bit destination. The low half holds the vector, delivery mode, addressing mode, level, trigger and a 2-bit destination shorthand. Writing the low half starts a send. Writing the high half only stores the destination.

The block turns the shorthand and delivery mode into a resolved message. That message carries a destination, an addressing bit, level and trigger values, a broadcast flag and an exclude-self flag. Receivers use the exclude-self flag to drop an all-but-sender message that matches their own ID. Most messages go out on a valid/ready port and are then accepted or refused. A self-only message is delivered internally as a one-cycle loopback pulse and never reaches the bus.

A read-only pending bit shows that a send is in progress. Refused messages are retried a limited number of times. Start-up messages are never retried. If every retry is refused, the block sets a sticky error flag.

On the bus port, a transfer takes place in every cycle where `msg_valid` and `msg_ready` are both high. `msg_nak` is sampled in that same cycle: 1 means the message was refused. While `msg_valid` is high and `msg_ready` is low, the message is held unchanged. Only the sink may stall the transfer.

Top module: `ipi_cmd_issuer`

## Requirements
- R1: After reset, `send_pending`, `send_err`, `msg_valid` and `lb_valid` are 0, and both read-back words are 0.
- R2: Shorthand 00 (low word bits 19:18) sends to the destination in high word bits 31:24. Broadcast is 0, exclude-self is 0, and `msg_logical` equals low word bit 11 (0 selects physical addressing, 1 selects logical addressing).
- R3: Shorthand 01 with any delivery mode other than 101 produces a one-cycle `lb_valid` pulse in the cycle after the write. The pulse carries the vector from bits 7:0 and the mode from bits 10:8. `msg_valid` stays 0 for that send.
- R4: Shorthand 10 sends destination 0xFF with broadcast 1 and exclude-self 0. `msg_logical` is taken from bit 11.
- R5: Shorthand 11 sends destination 0xFF with broadcast 1 and exclude-self 1. Physical addressing is forced (`msg_logical`=0).
- R6: Delivery mode 101 (INIT de-assert) goes on the bus as destination 0xFF with broadcast 1, exclude-self 0, physical addressing, level 0 and trigger 1. The shorthand and destination fields have no effect on it.
- R7: Every delivery mode other than 101 is issued with level 1 and trigger 0.
- R8: `send_pending` and read-back bit 12 of the low word read 1 from the cycle after a starting write until the send completes, and 0 otherwise. Read-back keeps the vector (7:0), mode (10:8), addressing (11), level (14), trigger (15) and shorthand (19:18) as written. All other low bits read 0.
- R9: A write to either half while `send_pending` is 1 is ignored. The stored fields and the outgoing message stay unchanged.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, the message stays valid and every message field stays stable.
- R11: A refused message in any mode other than 110 is resent. After MAX_RETRY (default 4) resends are also refused, which makes 5 attempts in total, the send ends and `send_err` is set. Acceptance on any attempt ends the send with no error.
- R12: A refused message in delivery mode 110 (start-up) ends the send after that one attempt, with no retry and no error.
- R13: `send_err` stays set until the next starting write. That write clears it in the cycle after.
- R14: A write to the high half while idle updates the destination read-back and starts no send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_hi | input | 1 | 1 selects the high (destination) half, 0 selects the low half |
| wr_data | input | 32 | Write data |
| rd_lo | output | 32 | Low half read-back, with the pending status in bit 12 |
| rd_hi | output | 32 | High half read-back, with the destination in bits 31:24 |
| send_pending | output | 1 | Send in progress |
| send_err | output | 1 | Sticky flag: all retries were refused |
| msg_valid | output | 1 | Bus message valid |
| msg_ready | input | 1 | Bus sink ready |
| msg_nak | input | 1 | Refusal, sampled when valid and ready |
| msg_dest | output | 8 | Resolved destination |
| msg_vector | output | 8 | Vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | Logical addressing |
| msg_level | output | 1 | Level |
| msg_trigger | output | 1 | Trigger |
| msg_bcast | output | 1 | Broadcast flag |
| msg_excl_self | output | 1 | Exclude-sender flag |
| lb_valid | output | 1 | Loopback delivery pulse |
| lb_vector | output | 8 | Loopback vector |
| lb_mode | output | 3 | Loopback delivery mode |

## Verification
Two functions can fall in the same cycle: a software write and an in-flight send. The bench provokes this by holding `msg_ready` low so that the send stalls, then writing new values to both halves. It then checks that the read-back and every message field still hold the original command. A refusal and the retry limit can also fall in the same cycle. The bench refuses every attempt and counts the handshakes until `send_pending` drops. It expects five attempts for an ordinary mode and exactly one for start-up, and it checks the error flag in each case.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int unsigned VEC_W  = 8;
  localparam int unsigned DEST_W = 8;
  localparam int unsigned MODE_W = 3;
  localparam int unsigned SH_W   = 2;

  localparam int unsigned POS_VEC   = 0;
  localparam int unsigned POS_MODE  = 8;
  localparam int unsigned POS_LOG   = 11;
  localparam int unsigned POS_STAT  = 12;
  localparam int unsigned POS_LVL   = 14;
  localparam int unsigned POS_TRIG  = 15;
  localparam int unsigned POS_SH    = 18;
  localparam int unsigned POS_DEST  = 24;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED    = 3'b000,
    DM_LOWEST   = 3'b001,
    DM_SMI      = 3'b010,
    DM_RSVD     = 3'b011,
    DM_NMI      = 3'b100,
    DM_INIT_DEA = 3'b101,
    DM_STARTUP  = 3'b110,
    DM_INIT     = 3'b111
  } dmode_e;

  typedef enum logic [SH_W-1:0] {
    SH_NONE     = 2'b00,
    SH_SELF     = 2'b01,
    SH_ALL_INCL = 2'b10,
    SH_ALL_EXCL = 2'b11
  } shorthand_e;

  typedef struct packed {
    logic [VEC_W-1:0] vector;
    dmode_e           mode;
    logic             logical;
    logic             level;
    logic             trigger;
    shorthand_e       sh;
  } cmd_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_BUS  = 2'b01,
    ST_LOOP = 2'b10
  } state_e;
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [31:0]       wr_data,
  input  logic              busy,
  output cmd_t              cmd,
  output logic [DEST_W-1:0] dest,
  output logic              start,
  output logic              start_self,
  output logic [31:0]       lo_word
);
  cmd_t wr_cmd;
  logic lo_wr, hi_wr;

  always_comb begin
    wr_cmd.vector  = wr_data[POS_VEC +: VEC_W];
    wr_cmd.mode    = dmode_e'(wr_data[POS_MODE +: MODE_W]);
    wr_cmd.logical = wr_data[POS_LOG];
    wr_cmd.level   = wr_data[POS_LVL];
    wr_cmd.trigger = wr_data[POS_TRIG];
    wr_cmd.sh      = shorthand_e'(wr_data[POS_SH +: SH_W]);
  end

  assign lo_wr      = wr_en && !wr_hi && !busy;
  assign hi_wr      = wr_en &&  wr_hi && !busy;
  assign start      = lo_wr;
  assign start_self = (wr_cmd.sh == SH_SELF) && (wr_cmd.mode != DM_INIT_DEA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd  <= '0;
      dest <= '0;
    end else begin
      if (lo_wr) cmd  <= wr_cmd;
      if (hi_wr) dest <= wr_data[POS_DEST +: DEST_W];
    end
  end

  always_comb begin
    lo_word = '0;
    lo_word[POS_VEC +: VEC_W]   = cmd.vector;
    lo_word[POS_MODE +: MODE_W] = cmd.mode;
    lo_word[POS_LOG]            = cmd.logical;
    lo_word[POS_LVL]            = cmd.level;
    lo_word[POS_TRIG]           = cmd.trigger;
    lo_word[POS_SH +: SH_W]     = cmd.sh;
  end
endmodule

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve
  import ipi_pkg::*;
(
  input  cmd_t              cmd,
  input  logic [DEST_W-1:0] dest_in,
  output logic [DEST_W-1:0] dest,
  output logic              logical,
  output logic              level,
  output logic              trigger,
  output logic              bcast,
  output logic              excl_self
);
  localparam logic [DEST_W-1:0] ALL_DEST = {DEST_W{1'b1}};

  always_comb begin
    dest      = dest_in;
    logical   = cmd.logical;
    level     = 1'b1;
    trigger   = 1'b0;
    bcast     = 1'b0;
    excl_self = 1'b0;
    if (cmd.mode == DM_INIT_DEA) begin
      dest    = ALL_DEST;
      logical = 1'b0;
      level   = 1'b0;
      trigger = 1'b1;
      bcast   = 1'b1;
    end else begin
      case (cmd.sh)
        SH_ALL_INCL: begin
          dest  = ALL_DEST;
          bcast = 1'b1;
        end
        SH_ALL_EXCL: begin
          dest      = ALL_DEST;
          bcast     = 1'b1;
          excl_self = 1'b1;
          logical   = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipi_send_fsm.sv
module ipi_send_fsm
  import ipi_pkg::*;
#(
  parameter int unsigned MAX_RETRY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic start_self,
  input  logic no_retry,
  input  logic msg_ready,
  input  logic msg_nak,
  output logic pending,
  output logic bus_valid,
  output logic loop_valid,
  output logic err
);
  localparam int unsigned CNT_W = $clog2(MAX_RETRY + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_RETRY);

  state_e           state;
  logic [CNT_W-1:0] retries;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      retries <= '0;
      err     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          err     <= 1'b0;
          retries <= '0;
          state   <= start_self ? ST_LOOP : ST_BUS;
        end
        ST_LOOP: state <= ST_IDLE;
        ST_BUS: if (msg_ready) begin
          if (!msg_nak || no_retry) begin
            state <= ST_IDLE;
          end else if (retries == CNT_MAX) begin
            state <= ST_IDLE;
            err   <= 1'b1;
          end else begin
            retries <= retries + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pending    = (state != ST_IDLE);
  assign bus_valid  = (state == ST_BUS);
  assign loop_valid = (state == ST_LOOP);
endmodule

// File: rtl/ipi_cmd_issuer.sv
module ipi_cmd_issuer
  import ipi_pkg::*;
#(
  parameter int unsigned MAX_RETRY = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_lo,
  output logic [31:0] rd_hi,
  output logic        send_pending,
  output logic        send_err,
  output logic        msg_valid,
  input  logic        msg_ready,
  input  logic        msg_nak,
  output logic [7:0]  msg_dest,
  output logic [7:0]  msg_vector,
  output logic [2:0]  msg_mode,
  output logic        msg_logical,
  output logic        msg_level,
  output logic        msg_trigger,
  output logic        msg_bcast,
  output logic        msg_excl_self,
  output logic        lb_valid,
  output logic [7:0]  lb_vector,
  output logic [2:0]  lb_mode
);
  cmd_t              cmd;
  logic [DEST_W-1:0] dest_q;
  logic              start, start_self;
  logic [31:0]       lo_word;

  ipi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .busy(send_pending), .cmd(cmd), .dest(dest_q), .start(start),
    .start_self(start_self), .lo_word(lo_word)
  );

  ipi_dest_resolve u_res (
    .cmd(cmd), .dest_in(dest_q), .dest(msg_dest), .logical(msg_logical),
    .level(msg_level), .trigger(msg_trigger), .bcast(msg_bcast),
    .excl_self(msg_excl_self)
  );

  ipi_send_fsm #(.MAX_RETRY(MAX_RETRY)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_self(start_self),
    .no_retry(cmd.mode == DM_STARTUP), .msg_ready(msg_ready), .msg_nak(msg_nak),
    .pending(send_pending), .bus_valid(msg_valid), .loop_valid(lb_valid),
    .err(send_err)
  );

  assign msg_vector = cmd.vector;
  assign msg_mode   = cmd.mode;
  assign lb_vector  = cmd.vector;
  assign lb_mode    = cmd.mode;

  always_comb begin
    rd_lo           = lo_word;
    rd_lo[POS_STAT] = send_pending;
    rd_hi           = '0;
    rd_hi[POS_DEST +: DEST_W] = dest_q;
  end
endmodule

// File: rtl/ipi_issuer_chk.sv
module ipi_issuer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_hi,
  input logic [31:0] rd_lo,
  input logic [31:0] rd_hi,
  input logic        send_pending,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic        msg_nak,
  input logic [7:0]  msg_dest,
  input logic [7:0]  msg_vector,
  input logic [2:0]  msg_mode,
  input logic        msg_logical,
  input logic        msg_level,
  input logic        msg_trigger,
  input logic        msg_bcast,
  input logic        msg_excl_self,
  input logic        lb_valid
);
  // R10
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest) && $stable(msg_vector)
      && $stable(msg_mode) && $stable(msg_bcast) && $stable(msg_excl_self));
  // R8
  pending_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid || lb_valid) |-> send_pending && rd_lo[12]);
  // R3
  loop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lb_valid && msg_valid));
  // R5
  excl_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_excl_self |-> msg_bcast && !msg_logical && msg_dest == 8'hFF);
  // R6
  init_dea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_mode == 3'b101 |-> msg_bcast && !msg_excl_self && !msg_level && msg_trigger);
  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_pending && wr_en |=> $stable(rd_lo[11:0]) && $stable(rd_lo[19:14]) && $stable(rd_hi));
  // R12
  startup_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready && msg_nak && msg_mode == 3'b110 |=> !msg_valid && !send_pending);
endmodule

bind ipi_cmd_issuer ipi_issuer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_hi), .rd_lo(rd_lo), .rd_hi(rd_hi),
  .send_pending(send_pending), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_nak(msg_nak), .msg_dest(msg_dest), .msg_vector(msg_vector), .msg_mode(msg_mode),
  .msg_logical(msg_logical), .msg_level(msg_level), .msg_trigger(msg_trigger),
  .msg_bcast(msg_bcast), .msg_excl_self(msg_excl_self), .lb_valid(lb_valid)
);

// File: tb/test_ipi_cmd_issuer.sv
`timescale 1ns/1ps
module test_ipi_cmd_issuer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_hi = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_lo, rd_hi;
  logic send_pending, send_err, msg_valid, msg_logical, msg_level, msg_trigger;
  logic msg_bcast, msg_excl_self, lb_valid;
  logic msg_ready = 1'b1, msg_nak = 1'b0;
  logic [7:0] msg_dest, msg_vector, lb_vector;
  logic [2:0] msg_mode, lb_mode;

  int errors = 0, checks = 0, cyc = 0;

  ipi_cmd_issuer i_ipi_cmd_issuer (.*);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic hi, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_hi = hi; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] lo_cmd(input int vec, input int mode, input int dm,
                                         input int lvl, input int trg, input int sh);
    return (32'(vec) & 32'hFF) | (32'(mode) << 8) | (32'(dm) << 11) |
           (32'(lvl) << 14) | (32'(trg) << 15) | (32'(sh) << 18);
  endfunction

  int attempts;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {send_pending, send_err, msg_valid, lb_valid}, 4'b0);
    chk("R1", {rd_lo, rd_hi}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // Sweep of every mode, shorthand and addressing bit: R2..R8
    for (int mode = 0; mode < 8; mode++) begin
      for (int sh = 0; sh < 4; sh++) begin
        for (int dm = 0; dm < 2; dm++) begin
          logic [7:0] d, vec, e_dest;
          logic e_log, e_lvl, e_trg, e_bc, e_ex;
          logic [31:0] lo;
          d   = 8'(8'h20 + mode * 8 + sh * 2 + dm);
          vec = 8'(8'h40 + mode * 8 + sh * 2 + dm);
          lo  = lo_cmd(vec, mode, dm, 1, 0, sh);
          do_write(1'b1, 32'(d) << 24);
          // R14 high write starts nothing
          chk("R14", {send_pending, msg_valid, lb_valid}, 3'b000);
          chk("R14", rd_hi, 32'(d) << 24);
          do_write(1'b0, lo);
          chk("R8", {send_pending, rd_lo}, {1'b1, lo | 32'h1000});
          if (sh == 1 && mode != 5) begin
            chk("R3", {lb_valid, msg_valid, lb_vector, lb_mode}, {2'b10, vec, 3'(mode)});
            @(negedge clk);
            chk("R3", {lb_valid, send_pending}, 2'b00);
          end else begin
            e_dest = d; e_log = dm[0]; e_lvl = 1'b1; e_trg = 1'b0; e_bc = 1'b0; e_ex = 1'b0;
            if (mode == 5) begin
              e_dest = 8'hFF; e_log = 1'b0; e_lvl = 1'b0; e_trg = 1'b1; e_bc = 1'b1;
            end else if (sh == 2) begin
              e_dest = 8'hFF; e_bc = 1'b1;
            end else if (sh == 3) begin
              e_dest = 8'hFF; e_bc = 1'b1; e_ex = 1'b1; e_log = 1'b0;
            end
            chk(mode == 5 ? "R6" : (sh == 0 ? "R2" : (sh == 2 ? "R4" : "R5")),
                {msg_valid, msg_dest, msg_vector, msg_mode, msg_logical, msg_bcast, msg_excl_self},
                {1'b1, e_dest, vec, 3'(mode), e_log, e_bc, e_ex});
            chk(mode == 5 ? "R6" : "R7", {msg_level, msg_trigger}, {e_lvl, e_trg});
            @(negedge clk);
            chk("R8", {send_pending, rd_lo[12], msg_valid}, 3'b000);
          end
        end
      end
    end

    // R10 / R9: back-pressure, writes while pending are ignored
    msg_ready = 1'b0;
    do_write(1'b1, 32'h5A00_0000);
    do_write(1'b0, lo_cmd(8'h33, 0, 0, 1, 0, 0));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10", {msg_valid, send_pending, msg_dest, msg_vector}, {2'b11, 8'h5A, 8'h33});
    end
    do_write(1'b0, lo_cmd(8'h44, 2, 1, 1, 0, 2));
    do_write(1'b1, 32'hA500_0000);
    chk("R9", {rd_lo[7:0], rd_lo[10:8], rd_lo[19:18], rd_hi[31:24]}, {8'h33, 3'd0, 2'd0, 8'h5A});
    chk("R9", {msg_dest, msg_vector, msg_bcast}, {8'h5A, 8'h33, 1'b0});
    msg_ready = 1'b1;
    @(negedge clk);
    chk("R10", send_pending, 1'b0);

    // R11: all attempts refused
    msg_nak = 1'b1;
    do_write(1'b0, lo_cmd(8'h61, 0, 0, 1, 0, 0));
    attempts = 0;
    for (int i = 0; i < 20 && send_pending; i++) begin
      if (msg_valid) attempts++;
      @(negedge clk);
    end
    chk("R11", 32'(attempts), 32'd5);
    chk("R11", {send_pending, send_err}, 2'b01);
    @(negedge clk);
    chk("R13", send_err, 1'b1);

    // R12 + R13: start-up refused once, err cleared by new send
    do_write(1'b0, lo_cmd(8'h62, 6, 0, 1, 0, 0));
    chk("R13", send_err, 1'b0);
    attempts = 0;
    for (int i = 0; i < 20 && send_pending; i++) begin
      if (msg_valid) attempts++;
      @(negedge clk);
    end
    chk("R12", 32'(attempts), 32'd1);
    chk("R12", {send_pending, send_err}, 2'b00);

    // R11: refused twice then accepted
    do_write(1'b0, lo_cmd(8'h63, 4, 0, 1, 0, 2));
    attempts = 0;
    for (int i = 0; i < 20 && send_pending; i++) begin
      if (msg_valid) begin
        attempts++;
        msg_nak = (attempts < 3);
      end
      @(negedge clk);
    end
    chk("R11", 32'(attempts), 32'd3);
    chk("R11", {send_pending, send_err}, 2'b00);
    msg_nak = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule